// File: doc/BRIEF.md
# Hot-Plug Slot Command Controller

This block executes the commands that a hot-plug controller receives as a command byte plus a target byte. It keeps a status word for each slot: slot power state, power indicator, attention indicator, latch-open flag and presence code. It also keeps a secondary bus speed field, three command error flags and a sticky command-complete flag. A command is presented on `cmdValid` together with `cmdCode` and `cmdTarget`. The block accepts it only while `busy` is low and holds `busy` high until the result is in place.

Single-slot commands move a slot through its power states under fixed transition rules. If a slot is switched off while its power indicator is off, it is reported as emptied: the latch reads open, the presence code reads empty, and latch and presence events are latched. Two group commands visit every slot in turn, one slot per cycle. They are refused when any slot is enabled. The occupancy of each slot is sampled from `presentInit` while reset is held.

Top module: `hp_slot_ctrl`

## Requirements
- R1: While `rst_n` is low, each slot whose `presentInit` bit is 1 is set to state 2 (enabled), power indicator 1 (on), latch closed and presence 0. Each other slot is set to state 3 (disabled), power indicator 3 (off), latch open and presence 3 (empty). In both cases attention is 0, bus speed is 0, the flags are clear and no events are latched. Slot s occupies `slotStatus[9s+8:9s]` as {presence[1:0], latchOpen, attn[1:0], power[1:0], state[1:0]}.
- R2: A code in 0x00..0x3F is a slot command with requested state in bits [1:0], power indicator in bits [3:2] and attention indicator in bits [5:4]. Each indicator field that is nonzero replaces the slot's indicator, and a zero field leaves it unchanged. Indicator values are 1 on, 2 blink, 3 off. State values are 1 power-only, 2 enabled, 3 disabled, and 0 requests no change.
- R3: The slot number is `cmdTarget[4:0]`, and number n selects slot n-1. A number of 0 or above NSLOTS sets `cmdInvalid` and leaves every slot unchanged.
- R4: A request for power-only on an enabled slot sets `cmdInvalid` and leaves the whole slot, indicators included, unchanged.
- R5: A disabled slot can move to power-only or to enabled, and a power-only or enabled slot can move to disabled. Any other request leaves the state as it is.
- R6: When a slot moves to disabled and its power indicator is off after the command's indicator update, the slot gets latch open and presence 3. Its `evtLatch` and `evtPresence` bits are also set, and they stay set until the matching `evtClr` bit is pulsed.
- R7: A code in 0x40..0x47 requests bus speed `cmdCode[2:0]`. Speed 0 is stored. Any other value sets `modeInvalid` and leaves `busSpeed` unchanged.
- R8: Codes 0x48 (group power-only) and 0x49 (group enable) set `cmdInvalid` and change no slot if any slot is enabled when the command executes.
- R9: Otherwise the group command applies to every slot, in slot order. A slot with its latch closed receives state 1 (for 0x48) or state 2 (for 0x49) with power indicator on. A slot with its latch open receives no state change with power indicator off. Attention is unchanged in both cases.
- R10: Any code above 0x49 sets `cmdInvalid`.
- R11: Accepting a command clears `cmdInvalid`, `modeInvalid` and `latchErr`. Every command sets `cmdDetected` when it ends, including a failed one. `cmdDetected` clears only on a `detClr` pulse.
- R12: `busy` rises at the edge that accepts a command. It stays high for 1 cycle for every command except a group command that walks the slots, which keeps it high for NSLOTS+1 cycles.
- R13: `cmdValid` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presentInit | input | NSLOTS | Slot occupancy, sampled during reset |
| cmdValid | input | 1 | Command request |
| cmdCode | input | 8 | Command code |
| cmdTarget | input | 8 | Target byte (low 5 bits used) |
| detClr | input | 1 | Clears cmdDetected |
| evtClr | input | NSLOTS | Clears the latched events of a slot |
| busy | output | 1 | Command in progress |
| cmdInvalid | output | 1 | Last command was invalid |
| modeInvalid | output | 1 | Last speed request was refused |
| latchErr | output | 1 | Latch-open command error (cleared at start) |
| cmdDetected | output | 1 | Sticky command-complete flag |
| busSpeed | output | 3 | Secondary bus speed code |
| slotStatus | output | 9*NSLOTS | Packed per-slot status |
| evtLatch | output | NSLOTS | Latched latch-open events |
| evtPresence | output | NSLOTS | Latched presence events |

## Verification
Directed sequences run each slot transition from every state: enable to power-only, which must change nothing; disable with the power indicator off, which must empty the slot; and disable with blink, which must keep the slot present. These cases separate the emptying side effect from a plain state change. Group commands are issued both with an enabled slot present, which must be refused, and with none, which must walk every slot. This distinguishes the refusal check from the walk and exposes the NSLOTS+1 busy window. A stray invalid code is driven during that window and must leave no trace. A seeded random mix of slot numbers in and out of range, indicator fields, speed codes and unknown codes is then compared after each command against a bench model that holds every slot's fields.

// File: rtl/hp_pkg.sv
package hp_pkg;

  localparam logic [1:0] ST_NONE  = 2'd0;
  localparam logic [1:0] ST_PWR   = 2'd1;
  localparam logic [1:0] ST_ENA   = 2'd2;
  localparam logic [1:0] ST_DIS   = 2'd3;
  localparam logic [1:0] LED_KEEP = 2'd0;
  localparam logic [1:0] LED_ON   = 2'd1;
  localparam logic [1:0] LED_OFF  = 2'd3;
  localparam logic [1:0] PRS_EMPTY = 2'd3;
  localparam int SLOT_W = 9;

  typedef struct packed {
    logic [1:0] presence;
    logic       latchOpen;
    logic [1:0] attn;
    logic [1:0] pwr;
    logic [1:0] state;
  } slot_t;

  typedef struct packed {
    slot_t s;
    logic  bad;
    logic  emptied;
  } apply_t;

  typedef struct packed {
    logic       startCmd;
    logic       doSlot;
    logic [4:0] slotIdx;
    logic [1:0] reqState;
    logic [1:0] reqPwr;
    logic [1:0] reqAttn;
    logic       doSpeed;
    logic [2:0] speedVal;
    logic       setInvalid;
    logic       finish;
  } strobe_t;

  function automatic apply_t slotApply(slot_t cur, logic [1:0] st,
                                       logic [1:0] pw, logic [1:0] at);
    apply_t r;
    r.s = cur;
    r.bad = 1'b0;
    r.emptied = 1'b0;
    if (cur.state == ST_ENA && st == ST_PWR) begin
      r.bad = 1'b1;
    end else begin
      if (pw != LED_KEEP) r.s.pwr = pw;
      if (at != LED_KEEP) r.s.attn = at;
      if (cur.state == ST_DIS && (st == ST_PWR || st == ST_ENA)) begin
        r.s.state = st;
      end else if ((cur.state == ST_ENA || cur.state == ST_PWR) && st == ST_DIS) begin
        r.s.state = st;
        if (r.s.pwr == LED_OFF) begin
          r.s.latchOpen = 1'b1;
          r.s.presence = PRS_EMPTY;
          r.emptied = 1'b1;
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/hp_ctrl.sv
module hp_ctrl
  import hp_pkg::*;
#(
  parameter int NSLOTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdValid,
  input  logic [7:0]        cmdCode,
  input  logic [7:0]        cmdTarget,
  input  logic              anyEnabled,
  input  logic [NSLOTS-1:0] latchOpenVec,
  output logic              busy,
  output strobe_t           stb
);
  localparam int IDXW = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NSLOTS - 1);

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_WALK} fsm_t;
  fsm_t fsmQ, fsmD;
  logic [7:0] codeQ;
  logic [4:0] targetQ;
  logic [IDXW-1:0] walkQ, walkD;
  logic accept;

  assign busy   = (fsmQ != S_IDLE);
  assign accept = cmdValid && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsmQ    <= S_IDLE;
      codeQ   <= '0;
      targetQ <= '0;
      walkQ   <= '0;
    end else begin
      fsmQ  <= fsmD;
      walkQ <= walkD;
      if (accept) begin
        codeQ   <= cmdCode;
        targetQ <= cmdTarget[4:0];
      end
    end
  end

  always_comb begin
    stb = '0;
    fsmD = fsmQ;
    walkD = walkQ;
    stb.startCmd = accept;
    case (fsmQ)
      S_IDLE: if (accept) fsmD = S_EXEC;
      S_EXEC: begin
        fsmD = S_IDLE;
        stb.finish = 1'b1;
        if (codeQ[7:6] == 2'b00) begin
          if (targetQ == 5'd0 || int'(targetQ) > NSLOTS) begin
            stb.setInvalid = 1'b1;
          end else begin
            stb.doSlot   = 1'b1;
            stb.slotIdx  = targetQ - 5'd1;
            stb.reqState = codeQ[1:0];
            stb.reqPwr   = codeQ[3:2];
            stb.reqAttn  = codeQ[5:4];
          end
        end else if (codeQ[7:3] == 5'b01000) begin
          stb.doSpeed  = 1'b1;
          stb.speedVal = codeQ[2:0];
        end else if (codeQ == 8'h48 || codeQ == 8'h49) begin
          if (anyEnabled) begin
            stb.setInvalid = 1'b1;
          end else begin
            stb.finish = 1'b0;
            fsmD  = S_WALK;
            walkD = '0;
          end
        end else begin
          stb.setInvalid = 1'b1;
        end
      end
      S_WALK: begin
        stb.doSlot  = 1'b1;
        stb.slotIdx = 5'(walkQ);
        if (latchOpenVec[walkQ]) begin
          stb.reqState = ST_NONE;
          stb.reqPwr   = LED_OFF;
        end else begin
          stb.reqState = codeQ[0] ? ST_ENA : ST_PWR;
          stb.reqPwr   = LED_ON;
        end
        stb.reqAttn = LED_KEEP;
        if (walkQ == LAST_IDX) begin
          stb.finish = 1'b1;
          fsmD = S_IDLE;
        end else begin
          walkD = walkQ + 1'b1;
        end
      end
      default: fsmD = S_IDLE;
    endcase
  end

  a_r12_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !busy) |=> busy);
  a_r13_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !stb.startCmd);
  a_r3_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    stb.doSlot |-> (int'(stb.slotIdx) < NSLOTS));
  a_r12_finish_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stb.finish |=> !busy);
endmodule

// File: rtl/hp_datapath.sv
module hp_datapath
  import hp_pkg::*;
#(
  parameter int NSLOTS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSLOTS-1:0]        presentInit,
  input  strobe_t                  stb,
  input  logic                     detClr,
  input  logic [NSLOTS-1:0]        evtClr,
  output logic                     anyEnabled,
  output logic [NSLOTS-1:0]        latchOpenVec,
  output logic                     cmdInvalid,
  output logic                     modeInvalid,
  output logic                     latchErr,
  output logic                     cmdDetected,
  output logic [2:0]               busSpeed,
  output logic [SLOT_W*NSLOTS-1:0] slotStatus,
  output logic [NSLOTS-1:0]        evtLatch,
  output logic [NSLOTS-1:0]        evtPresence
);
  slot_t  slotQ [NSLOTS];
  slot_t  selSlot;
  apply_t res;
  logic [NSLOTS-1:0] enaVec;

  always_comb begin
    selSlot = slotQ[0];
    for (int i = 0; i < NSLOTS; i++)
      if (int'(stb.slotIdx) == i) selSlot = slotQ[i];
  end
  assign res = slotApply(selSlot, stb.reqState, stb.reqPwr, stb.reqAttn);
  assign anyEnabled = |enaVec;

  for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
    logic hit;
    assign hit = stb.doSlot && (int'(stb.slotIdx) == g);
    assign enaVec[g] = (slotQ[g].state == ST_ENA);
    assign latchOpenVec[g] = slotQ[g].latchOpen;
    assign slotStatus[g*SLOT_W +: SLOT_W] = slotQ[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        evtLatch[g]    <= 1'b0;
        evtPresence[g] <= 1'b0;
        if (presentInit[g])
          slotQ[g] <= '{presence: 2'd0, latchOpen: 1'b0, attn: 2'd0,
                        pwr: LED_ON, state: ST_ENA};
        else
          slotQ[g] <= '{presence: PRS_EMPTY, latchOpen: 1'b1, attn: 2'd0,
                        pwr: LED_OFF, state: ST_DIS};
      end else begin
        if (evtClr[g]) begin
          evtLatch[g]    <= 1'b0;
          evtPresence[g] <= 1'b0;
        end
        if (hit) begin
          slotQ[g] <= res.s;
          if (res.emptied) begin
            evtLatch[g]    <= 1'b1;
            evtPresence[g] <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdInvalid  <= 1'b0;
      modeInvalid <= 1'b0;
      latchErr    <= 1'b0;
      cmdDetected <= 1'b0;
      busSpeed    <= 3'd0;
    end else begin
      if (stb.startCmd) begin
        cmdInvalid  <= 1'b0;
        modeInvalid <= 1'b0;
        latchErr    <= 1'b0;
      end
      if (stb.setInvalid || (stb.doSlot && res.bad)) cmdInvalid <= 1'b1;
      if (stb.doSpeed) begin
        if (stb.speedVal == 3'd0) busSpeed <= 3'd0;
        else modeInvalid <= 1'b1;
      end
      if (detClr) cmdDetected <= 1'b0;
      if (stb.finish) cmdDetected <= 1'b1;
    end
  end

  a_r11_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    stb.startCmd |=> (!cmdInvalid && !modeInvalid && !latchErr));
  a_r11_detect_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    stb.finish |=> cmdDetected);
  a_r5_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.doSlot |=> $stable(slotStatus));
  a_r7_speed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.doSpeed && stb.speedVal != 3'd0) |=> (modeInvalid && $stable(busSpeed)));
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_pkg::*;
#(
  parameter int NSLOTS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSLOTS-1:0]        presentInit,
  input  logic                     cmdValid,
  input  logic [7:0]               cmdCode,
  input  logic [7:0]               cmdTarget,
  input  logic                     detClr,
  input  logic [NSLOTS-1:0]        evtClr,
  output logic                     busy,
  output logic                     cmdInvalid,
  output logic                     modeInvalid,
  output logic                     latchErr,
  output logic                     cmdDetected,
  output logic [2:0]               busSpeed,
  output logic [SLOT_W*NSLOTS-1:0] slotStatus,
  output logic [NSLOTS-1:0]        evtLatch,
  output logic [NSLOTS-1:0]        evtPresence
);
  strobe_t stb;
  logic anyEnabled;
  logic [NSLOTS-1:0] latchOpenVec;

  hp_ctrl #(.NSLOTS(NSLOTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdTarget(cmdTarget), .anyEnabled(anyEnabled),
    .latchOpenVec(latchOpenVec), .busy(busy), .stb(stb)
  );

  hp_datapath #(.NSLOTS(NSLOTS)) u_dp (
    .clk(clk), .rst_n(rst_n), .presentInit(presentInit), .stb(stb),
    .detClr(detClr), .evtClr(evtClr), .anyEnabled(anyEnabled),
    .latchOpenVec(latchOpenVec), .cmdInvalid(cmdInvalid),
    .modeInvalid(modeInvalid), .latchErr(latchErr),
    .cmdDetected(cmdDetected), .busSpeed(busSpeed),
    .slotStatus(slotStatus), .evtLatch(evtLatch), .evtPresence(evtPresence)
  );
endmodule

// File: tb/hp_slot_ctrl_tb.sv
module hp_slot_ctrl_tb;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] presentInit = '0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdCode = '0, cmdTarget = '0;
  logic detClr = 1'b0;
  logic [N-1:0] evtClr = '0;
  logic busy, cmdInvalid, modeInvalid, latchErr, cmdDetected;
  logic [2:0] busSpeed;
  logic [9*N-1:0] slotStatus;
  logic [N-1:0] evtLatch, evtPresence;

  int nChecks = 0, nFails = 0;

  logic [1:0] mState [N], mPwr [N], mAttn [N], mPrs [N];
  logic mLatch [N], mEvL [N], mEvP [N];
  logic mInv, mMode;
  logic [2:0] mSpeed;

  always #2.5 clk = ~clk;

  hp_slot_ctrl #(.NSLOTS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .presentInit(presentInit), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .cmdTarget(cmdTarget), .detClr(detClr), .evtClr(evtClr),
    .busy(busy), .cmdInvalid(cmdInvalid), .modeInvalid(modeInvalid),
    .latchErr(latchErr), .cmdDetected(cmdDetected), .busSpeed(busSpeed),
    .slotStatus(slotStatus), .evtLatch(evtLatch), .evtPresence(evtPresence)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [9*N-1:0] expStatus();
    logic [9*N-1:0] v;
    for (int s = 0; s < N; s++) v[s*9 +: 9] = {mPrs[s], mLatch[s], mAttn[s], mPwr[s], mState[s]};
    return v;
  endfunction

  function automatic logic [N-1:0] expEvL();
    logic [N-1:0] v;
    for (int s = 0; s < N; s++) v[s] = mEvL[s];
    return v;
  endfunction

  function automatic logic [N-1:0] expEvP();
    logic [N-1:0] v;
    for (int s = 0; s < N; s++) v[s] = mEvP[s];
    return v;
  endfunction

  task automatic modelSlot(input int s, input logic [1:0] st, input logic [1:0] pw, input logic [1:0] at);
    logic [1:0] cur;
    cur = mState[s];
    if (cur == 2 && st == 1) begin mInv = 1; return; end
    if (pw != 0) mPwr[s] = pw;
    if (at != 0) mAttn[s] = at;
    if (cur == 3 && (st == 1 || st == 2)) mState[s] = st;
    else if ((cur == 1 || cur == 2) && st == 3) begin
      mState[s] = 3;
      if (mPwr[s] == 3) begin
        mLatch[s] = 1; mPrs[s] = 3; mEvL[s] = 1; mEvP[s] = 1;
      end
    end
  endtask

  function automatic logic anyEna();
    for (int s = 0; s < N; s++) if (mState[s] == 2) return 1'b1;
    return 1'b0;
  endfunction

  task automatic compareAll(input string tag);
    check(64'(slotStatus), 64'(expStatus()), {tag, " status"});
    check(64'(cmdInvalid), 64'(mInv), {tag, " cmdInvalid"});
    check(64'(modeInvalid), 64'(mMode), {tag, " R7 modeInvalid"});
    check(64'(busSpeed), 64'(mSpeed), {tag, " R7 busSpeed"});
    check(64'(evtLatch), 64'(expEvL()), {tag, " R6 evtLatch"});
    check(64'(evtPresence), 64'(expEvP()), {tag, " R6 evtPresence"});
  endtask

  task automatic doReset(input logic [N-1:0] occ);
    rst_n = 0; presentInit = occ;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < N; s++) begin
      mState[s] = occ[s] ? 2'd2 : 2'd3;
      mPwr[s]   = occ[s] ? 2'd1 : 2'd3;
      mLatch[s] = !occ[s];
      mPrs[s]   = occ[s] ? 2'd0 : 2'd3;
      mAttn[s] = 0; mEvL[s] = 0; mEvP[s] = 0;
    end
    mInv = 0; mMode = 0; mSpeed = 0;
    compareAll("R1 reset");
    check(64'({busy, cmdDetected, latchErr}), 64'd0, "R1 reset flags");
  endtask

  task automatic doCmd(input logic [7:0] code, input logic [7:0] tgt, input bit inject, input string tag);
    int n, expN;
    logic [4:0] t;
    bit walk;
    expN = 1;
    mInv = 0; mMode = 0;
    t = tgt[4:0];
    if (code <= 8'h3F) begin
      if (t == 0 || int'(t) > N) mInv = 1;
      else modelSlot(int'(t) - 1, code[1:0], code[3:2], code[5:4]);
    end else if (code <= 8'h47) begin
      if (code[2:0] == 0) mSpeed = 0; else mMode = 1;
    end else if (code == 8'h48 || code == 8'h49) begin
      walk = !anyEna();
      if (!walk) mInv = 1;
      else begin
        expN = N + 1;
        for (int s = 0; s < N; s++) begin
          if (!mLatch[s]) modelSlot(s, (code == 8'h49) ? 2'd2 : 2'd1, 2'd1, 2'd0);
          else modelSlot(s, 2'd0, 2'd3, 2'd0);
        end
      end
    end else mInv = 1;
    cmdValid = 1; cmdCode = code; cmdTarget = tgt;
    @(negedge clk);
    cmdValid = 0;
    n = 0;
    check(64'(latchErr), 64'd0, {tag, " R11 cleared"});
    if (inject) begin
      cmdValid = 1; cmdCode = 8'hFF; cmdTarget = 8'h01;
    end
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
      cmdValid = 0;
    end
    check(64'(n), 64'(expN), {tag, " R12 busy cycles"});
    check(64'(cmdDetected), 64'd1, {tag, " R11 detected"});
    compareAll(tag);
    detClr = 1; @(negedge clk); detClr = 0;
    check(64'(cmdDetected), 64'd0, {tag, " R11 detClr"});
  endtask

  initial begin
    logic [7:0] c, tg;
    int pick;
    void'($urandom(32'h1234abcd));
    doReset(4'b0101);
    doCmd(8'h49, 8'h00, 0, "R8 refused enable");
    doCmd(8'h48, 8'h00, 0, "R8 refused pwronly");
    doCmd(8'h03, 8'h00, 0, "R3 target zero");
    doCmd(8'h03, 8'h05, 0, "R3 target high");
    doCmd(8'h21, 8'h01, 0, "R4 ena to pwronly");
    doCmd(8'h0F, 8'h01, 0, "R6 disable off");
    doCmd(8'h0B, 8'h03, 0, "R5 disable blink");
    doCmd(8'h1B, 8'h03, 0, "R2 attn only");
    doCmd(8'h43, 8'h00, 0, "R7 bad speed");
    doCmd(8'h40, 8'h00, 0, "R7 speed zero");
    doCmd(8'h50, 8'h00, 0, "R10 unknown code");
    doCmd(8'h48, 8'h00, 1, "R9 R13 group pwronly");
    doCmd(8'h01, 8'h03, 0, "R5 pwronly stays");
    doCmd(8'h0B, 8'h03, 0, "R5 pwronly to disabled");
    doCmd(8'h49, 8'hE3, 0, "R9 group enable");
    evtClr = '1; @(negedge clk); evtClr = '0;
    check(64'(evtLatch | evtPresence), 64'd0, "R6 evtClr");
    for (int s = 0; s < N; s++) begin mEvL[s] = 0; mEvP[s] = 0; end
    for (int k = 0; k < 300; k++) begin
      pick = $urandom_range(0, 9);
      tg = {3'($urandom), 5'($urandom_range(0, N + 2))};
      if (pick < 6) c = {2'b00, 6'($urandom)};
      else if (pick == 6) c = 8'h40 | 8'($urandom_range(0, 7));
      else if (pick == 7) c = 8'h48 | 8'($urandom_range(0, 1));
      else c = 8'($urandom_range(8'h4A, 8'hFF));
      if (k % 50 == 49) doReset(N'($urandom));
      doCmd(c, tg, 0, "R2 R5 random");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog R12 actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule